// File: doc/BRIEF.md
# Contactless Card Session Sequencer

This block runs a complete read session against a contactless memory card. It switches on the field carrier and waits for the card to charge. It then sends a fixed setup frame with no keystream and seeds an external keystream generator. It reads back a card-type code and acknowledges the card. From the type code it picks the command width and the card size. It then reads the card one byte per command. Each reply byte is checked against a 4-bit CRC that is recomputed serially inside the block.

The block connects to a frame transmitter and to a frame receiver through request/done handshakes. A frame request states the payload and its bit count. A receive request states how many bits are expected. The keystream generator is external: this block only pulses its seed load and its step input. Bytes that pass the CRC go out through a one-cycle write strobe, with a buffer index that counts from zero. The session ends with the carrier held off long enough for the card to reset. One of two sticky flags then reports success or failure.

Top module: `card_read_seq`

## Requirements
- R1: After a start strobe the carrier goes high at once and stays high for at least CHARGE_CYC clock cycles before the first frame request.
- R2: The first frame is the 7-bit value 0x55 with the plain (no keystream) flag set. After it completes, the keystream generator is seeded once with 0x55, and then a 6-bit type reply is requested.
- R3: Type code 0x1D selects 9-bit read commands and a 256-byte card. Type code 0x3D selects 11-bit read commands and a 1024-byte card. type_o shows the received code.
- R4: Any other type code drops the carrier, issues no further frame, writes nothing and ends the session with err_o.
- R5: After a valid type, the keystream is stepped once and the 6-bit value 0x19 is sent. The acknowledge frame and every read command start no sooner than GAP_TICKS ticks (TICK_DIV clocks each) after the end of the previous frame.
- R6: Exactly four keystream step pulses occur between the previous frame and each read command.
- R7: A read command carries the value (card address << 1) | 1 with the selected width, and a 12-bit reply is then requested. The reply's bits 7:0 are the data byte and bits 11:8 are its CRC.
- R8: The CRC is 4 bits wide with polynomial 0xC, start value 0x5 and no output inversion. At each bit, MSB first, the register shifts left one place and XORs in 0xC when the bit shifted out differs from the input bit. It is fed a 1, then the address in (width-1) bits, then the data byte. On a match, wr_en_o pulses once with wr_addr_o equal to the buffer index (0, 1, …) and wr_data_o equal to the byte.
- R9: On a CRC mismatch, nothing is written for that byte, no further command is sent and the session ends with err_o.
- R10: The number of bytes read is the count, clipped so that offset plus count does not exceed the card size. An offset at or beyond the card size reads nothing.
- R11: Every session ends with the carrier low for at least OFF_CYC cycles, followed by exactly one of done_o or err_o. The flag holds until the next start, which clears both.
- R12: Reset, even in mid-session, returns the block to idle with the carrier low, no requests and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| offset_i | input | 10 | First card address to read |
| count_i | input | 11 | Number of bytes requested |
| carrier_o | output | 1 | Field carrier enable |
| tx_req_o | output | 1 | Frame send request, held until tx_done_i |
| tx_data_o | output | 11 | Frame payload, LSB sent first |
| tx_bits_o | output | 4 | Frame length in bits |
| tx_plain_o | output | 1 | Send without keystream |
| tx_done_i | input | 1 | Transmitter finished the frame |
| rx_req_o | output | 1 | Receive request, held until rx_done_i |
| rx_bits_o | output | 4 | Bits to receive |
| rx_data_i | input | 12 | Decrypted received bits |
| rx_done_i | input | 1 | Receiver finished |
| ks_load_o | output | 1 | Keystream seed load pulse |
| ks_seed_o | output | 7 | Keystream seed value |
| ks_step_o | output | 1 | Keystream single-step pulse |
| wr_en_o | output | 1 | Byte store strobe |
| wr_addr_o | output | 10 | Buffer index of stored byte |
| wr_data_o | output | 8 | Stored byte |
| done_o | output | 1 | Session finished successfully |
| err_o | output | 1 | Session aborted |
| type_o | output | 6 | Card type code received |

## Verification
A corrupted address or command width shows in the very next read command as a wrong payload or bit count. A wrong serial CRC state appears once that reply completes, as a missing write strobe together with a premature err_o. A mis-counted keystream step, a short inter-frame gap or a wrong clip of the byte count shows at the frame handshake or in the number of writes before the end flag. A stuck sequencer state shows within one session as a missing done_o or err_o.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int OFS_W   = 10;
   localparam int CNT_W   = 11;
   localparam int CMD_W   = 11;
   localparam int REPLY_W = 12;
   localparam int TYPE_W  = 6;
   localparam int MSG_W   = 1 + OFS_W + 8;
   localparam int NB_W    = $clog2(MSG_W + 1);

   localparam logic [TYPE_W-1:0] TYPE_SMALL = 6'h1D;
   localparam logic [TYPE_W-1:0] TYPE_LARGE = 6'h3D;
   localparam logic [6:0]        SETUP_VAL  = 7'h55;
   localparam logic [5:0]        ACK_VAL    = 6'h19;
   localparam logic [3:0]        CRC_POLY   = 4'hC;
   localparam logic [3:0]        CRC_INIT   = 4'h5;

   typedef enum logic [3:0] {
      S_IDLE, S_CHARGE, S_TX_SET, S_SEED, S_RX_TYPE, S_DECODE, S_GAP_ACK,
      S_TX_ACK, S_NEXT, S_STEP, S_GAP_RD, S_TX_RD, S_RX_RD, S_CRC, S_CHECK,
      S_OFF
   } seq_st_t;

   function automatic logic [3:0] crc4_step(input logic [3:0] cur, input logic din);
      logic [3:0] sh;
      sh = {cur[2:0], 1'b0};
      return (cur[3] ^ din) ? (sh ^ CRC_POLY) : sh;
   endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int TICK_DIV  = 32,
   parameter int GAP_TICKS = 387,
   parameter int WAIT_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WAIT_W-1:0] load_val_i,
   output logic              wait_zero_o,
   input  logic              gap_clr_i,
   output logic              gap_ok_o
);
   localparam int GAP_W = $clog2(GAP_TICKS + 1);

   logic [WAIT_W-1:0] wait_q;
   logic [GAP_W-1:0]  gap_q;
   logic              tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             wait_q <= '0;
      else if (load_i)        wait_q <= load_val_i;
      else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
   end
   assign wait_zero_o = (wait_q == '0);

   generate
      if (TICK_DIV == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_div
         localparam int DIV_W = $clog2(TICK_DIV);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else if (gap_clr_i || div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       gap_q <= '0;
      else if (gap_clr_i)                               gap_q <= '0;
      else if (tick && gap_q < GAP_W'(GAP_TICKS))       gap_q <= gap_q + 1'b1;
   end
   assign gap_ok_o = (gap_q >= GAP_W'(GAP_TICKS));
endmodule

// File: rtl/seq_crc4.sv
module seq_crc4
   import seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [MSG_W-1:0] msg_i,
   input  logic [NB_W-1:0]  nbits_i,
   output logic [3:0]       crc_o,
   output logic             valid_o
);
   logic [MSG_W-1:0] sh_q;
   logic [NB_W-1:0]  left_q;
   logic [3:0]       crc_q;
   logic             run_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0; left_q <= '0; crc_q <= CRC_INIT; run_q <= 1'b0; valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_i) begin
            sh_q   <= msg_i;
            left_q <= nbits_i;
            crc_q  <= CRC_INIT;
            run_q  <= 1'b1;
         end else if (run_q) begin
            crc_q  <= crc4_step(crc_q, sh_q[MSG_W-1]);
            sh_q   <= {sh_q[MSG_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
            if (left_q == NB_W'(1)) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end
   assign crc_o   = crc_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/card_read_seq.sv
module card_read_seq
   import seq_pkg::*;
#(
   parameter int CHARGE_CYC = 48000,
   parameter int OFF_CYC    = 480000,
   parameter int TICK_DIV   = 32,
   parameter int GAP_TICKS  = 387
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [OFS_W-1:0]   offset_i,
   input  logic [CNT_W-1:0]   count_i,
   output logic               carrier_o,
   output logic               tx_req_o,
   output logic [CMD_W-1:0]   tx_data_o,
   output logic [3:0]         tx_bits_o,
   output logic               tx_plain_o,
   input  logic               tx_done_i,
   output logic               rx_req_o,
   output logic [3:0]         rx_bits_o,
   input  logic [REPLY_W-1:0] rx_data_i,
   input  logic               rx_done_i,
   output logic               ks_load_o,
   output logic [6:0]         ks_seed_o,
   output logic               ks_step_o,
   output logic               wr_en_o,
   output logic [OFS_W-1:0]   wr_addr_o,
   output logic [7:0]         wr_data_o,
   output logic               done_o,
   output logic               err_o,
   output logic [TYPE_W-1:0]  type_o
);
   localparam int LONGEST = (CHARGE_CYC > OFF_CYC) ? CHARGE_CYC : OFF_CYC;
   localparam int WAIT_W  = $clog2(LONGEST + 1);

   generate
      if (TICK_DIV < 1)   begin : g_bad_div    $error("TICK_DIV must be at least 1");   end
      if (GAP_TICKS < 1)  begin : g_bad_gap    $error("GAP_TICKS must be at least 1");  end
      if (CHARGE_CYC < 1) begin : g_bad_charge $error("CHARGE_CYC must be at least 1"); end
      if (OFF_CYC < 1)    begin : g_bad_off    $error("OFF_CYC must be at least 1");    end
   endgenerate

   seq_st_t            st_q;
   logic [OFS_W-1:0]   offs_q;
   logic [CNT_W-1:0]   want_q, nbytes_q, idx_q;
   logic [TYPE_W-1:0]  type_q;
   logic [REPLY_W-1:0] reply_q;
   logic [1:0]         step_q;
   logic               wide_q, bad_q, carrier_q, done_q, err_q;

   logic               tmr_load, wait_zero, gap_ok, gap_clr;
   logic [WAIT_W-1:0]  tmr_val;
   logic               crc_start, crc_valid;
   logic [3:0]         crc_val;
   logic [MSG_W-1:0]   crc_msg;
   logic [NB_W-1:0]    crc_nb;
   logic [OFS_W-1:0]   card_addr;
   logic               type_good, type_wide;
   logic [CNT_W-1:0]   size_sel, room, clip;
   logic               crc_ok;

   assign card_addr = offs_q + idx_q[OFS_W-1:0];
   assign type_good = (type_q == TYPE_SMALL) || (type_q == TYPE_LARGE);
   assign type_wide = (type_q == TYPE_LARGE);
   assign size_sel  = type_wide ? CNT_W'(1024) : CNT_W'(256);
   assign room      = size_sel - CNT_W'(offs_q);
   assign clip      = (CNT_W'(offs_q) >= size_sel) ? '0 :
                      (want_q > room) ? room : want_q;
   assign crc_ok    = (crc_val == reply_q[11:8]);
   assign gap_clr   = tx_done_i || rx_done_i;

   assign crc_start = (st_q == S_RX_RD) && rx_done_i;
   assign crc_msg   = wide_q ? {1'b1, card_addr, rx_data_i[7:0]}
                             : {1'b1, card_addr[7:0], rx_data_i[7:0], 2'b00};
   assign crc_nb    = wide_q ? NB_W'(MSG_W) : NB_W'(MSG_W - 2);

   // timer reload: charge on start, carrier-off hold on every exit path
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = WAIT_W'(OFF_CYC);
      unique case (st_q)
         S_IDLE:   if (start_i) begin tmr_load = 1'b1; tmr_val = WAIT_W'(CHARGE_CYC); end
         S_DECODE: tmr_load = !type_good;
         S_NEXT:   tmr_load = (idx_q == nbytes_q);
         S_CHECK:  tmr_load = !crc_ok;
         default:  tmr_load = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; offs_q <= '0; want_q <= '0; nbytes_q <= '0; idx_q <= '0;
         type_q <= '0; reply_q <= '0; step_q <= '0; wide_q <= 1'b0; bad_q <= 1'b0;
         carrier_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: if (start_i) begin
               offs_q <= offset_i; want_q <= count_i; idx_q <= '0;
               done_q <= 1'b0; err_q <= 1'b0; carrier_q <= 1'b1; st_q <= S_CHARGE;
            end
            S_CHARGE:  if (wait_zero) st_q <= S_TX_SET;
            S_TX_SET:  if (tx_done_i) st_q <= S_SEED;
            S_SEED:    st_q <= S_RX_TYPE;
            S_RX_TYPE: if (rx_done_i) begin type_q <= rx_data_i[TYPE_W-1:0]; st_q <= S_DECODE; end
            S_DECODE:
               if (type_good) begin
                  wide_q <= type_wide; nbytes_q <= clip; st_q <= S_GAP_ACK;
               end else begin
                  bad_q <= 1'b1; carrier_q <= 1'b0; st_q <= S_OFF;
               end
            S_GAP_ACK: if (gap_ok) st_q <= S_TX_ACK;
            S_TX_ACK:  if (tx_done_i) st_q <= S_NEXT;
            S_NEXT:
               if (idx_q == nbytes_q) begin
                  bad_q <= 1'b0; carrier_q <= 1'b0; st_q <= S_OFF;
               end else begin
                  step_q <= '0; st_q <= S_STEP;
               end
            S_STEP: begin
               step_q <= step_q + 1'b1;
               if (step_q == 2'd3) st_q <= S_GAP_RD;
            end
            S_GAP_RD: if (gap_ok) st_q <= S_TX_RD;
            S_TX_RD:  if (tx_done_i) st_q <= S_RX_RD;
            S_RX_RD:  if (rx_done_i) begin reply_q <= rx_data_i; st_q <= S_CRC; end
            S_CRC:    if (crc_valid) st_q <= S_CHECK;
            S_CHECK:
               if (crc_ok) begin
                  idx_q <= idx_q + 1'b1; st_q <= S_NEXT;
               end else begin
                  bad_q <= 1'b1; carrier_q <= 1'b0; st_q <= S_OFF;
               end
            S_OFF: if (wait_zero) begin
               done_q <= !bad_q; err_q <= bad_q; st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_req_o   = 1'b0;
      tx_data_o  = '0;
      tx_bits_o  = '0;
      tx_plain_o = 1'b0;
      rx_req_o   = 1'b0;
      rx_bits_o  = '0;
      unique case (st_q)
         S_TX_SET: begin
            tx_req_o = 1'b1; tx_data_o = CMD_W'(SETUP_VAL); tx_bits_o = 4'd7; tx_plain_o = 1'b1;
         end
         S_TX_ACK: begin
            tx_req_o = 1'b1; tx_data_o = CMD_W'(ACK_VAL); tx_bits_o = 4'd6;
         end
         S_TX_RD: begin
            tx_req_o  = 1'b1;
            tx_data_o = wide_q ? {card_addr, 1'b1} : {2'b00, card_addr[7:0], 1'b1};
            tx_bits_o = wide_q ? 4'd11 : 4'd9;
         end
         S_RX_TYPE: begin rx_req_o = 1'b1; rx_bits_o = 4'd6;  end
         S_RX_RD:   begin rx_req_o = 1'b1; rx_bits_o = 4'd12; end
         default: ;
      endcase
   end

   assign ks_load_o = (st_q == S_SEED);
   assign ks_seed_o = SETUP_VAL;
   assign ks_step_o = (st_q == S_STEP) || (st_q == S_DECODE && type_good);
   assign wr_en_o   = (st_q == S_CHECK) && crc_ok;
   assign wr_addr_o = idx_q[OFS_W-1:0];
   assign wr_data_o = reply_q[7:0];
   assign carrier_o = carrier_q;
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign type_o    = type_q;

   seq_timer #(.TICK_DIV(TICK_DIV), .GAP_TICKS(GAP_TICKS), .WAIT_W(WAIT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
      .wait_zero_o(wait_zero), .gap_clr_i(gap_clr), .gap_ok_o(gap_ok));

   seq_crc4 i_crc (
      .clk(clk), .rst_n(rst_n), .start_i(crc_start), .msg_i(crc_msg), .nbits_i(crc_nb),
      .crc_o(crc_val), .valid_o(crc_valid));
endmodule

// File: rtl/card_read_seq_chk.sv
module card_read_seq_chk
   import seq_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [OFS_W-1:0]   offset_i,
   input logic [CNT_W-1:0]   count_i,
   input logic               carrier_o,
   input logic               tx_req_o,
   input logic [CMD_W-1:0]   tx_data_o,
   input logic [3:0]         tx_bits_o,
   input logic               tx_plain_o,
   input logic               tx_done_i,
   input logic               rx_req_o,
   input logic [3:0]         rx_bits_o,
   input logic [REPLY_W-1:0] rx_data_i,
   input logic               rx_done_i,
   input logic               ks_load_o,
   input logic [6:0]         ks_seed_o,
   input logic               ks_step_o,
   input logic               wr_en_o,
   input logic [OFS_W-1:0]   wr_addr_o,
   input logic [7:0]         wr_data_o,
   input logic               done_o,
   input logic               err_o,
   input logic [TYPE_W-1:0]  type_o
);
   a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   a_r11_carrier_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || err_o) |-> !carrier_o);
   a_r1_frame_needs_carrier: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req_o |-> carrier_o);
   a_r2_plain_is_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req_o && tx_plain_o) |-> (tx_data_o == CMD_W'(SETUP_VAL) && tx_bits_o == 4'd7));
   a_r3_cmd_width_follows_type: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req_o && tx_bits_o >= 4'd9) |-> (tx_bits_o == ((type_o == TYPE_LARGE) ? 4'd11 : 4'd9)));
   a_r7_reply_needs_known_type: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req_o && rx_bits_o == 4'd12) |-> (type_o == TYPE_SMALL || type_o == TYPE_LARGE));
   a_r6_no_step_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
      ks_step_o |-> !tx_req_o && !rx_req_o);
   a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);
   a_r9_no_write_when_ended: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !err_o && !done_o);
endmodule

bind card_read_seq card_read_seq_chk i_chk (.*);

// File: tb/test_card_read_seq.sv
module test_card_read_seq;
   localparam int CH = 40, OFFC = 60, DIV = 2, GAP = 387;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [9:0]  offset_i = '0;
   logic [10:0] count_i = '0;
   logic        carrier_o, tx_req_o, tx_plain_o, rx_req_o, ks_load_o, ks_step_o;
   logic [10:0] tx_data_o;
   logic [3:0]  tx_bits_o, rx_bits_o;
   logic        tx_done_i = 1'b0, rx_done_i = 1'b0;
   logic [11:0] rx_data_i = '0;
   logic [6:0]  ks_seed_o;
   logic        wr_en_o, done_o, err_o;
   logic [9:0]  wr_addr_o;
   logic [7:0]  wr_data_o;
   logic [5:0]  type_o;

   always #4 clk = ~clk;

   card_read_seq #(.CHARGE_CYC(CH), .OFF_CYC(OFFC), .TICK_DIV(DIV), .GAP_TICKS(GAP)) i_card_read_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i), .count_i(count_i),
      .carrier_o(carrier_o), .tx_req_o(tx_req_o), .tx_data_o(tx_data_o), .tx_bits_o(tx_bits_o),
      .tx_plain_o(tx_plain_o), .tx_done_i(tx_done_i), .rx_req_o(rx_req_o), .rx_bits_o(rx_bits_o),
      .rx_data_i(rx_data_i), .rx_done_i(rx_done_i), .ks_load_o(ks_load_o), .ks_seed_o(ks_seed_o),
      .ks_step_o(ks_step_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .done_o(done_o), .err_o(err_o), .type_o(type_o));

   int n_tests = 0, n_fail = 0;

   // card type, offset, count, corrupted address (-1 none), expect error, expected bytes
   localparam int VEC [8][6] = '{
      '{'h1D,    0,  5, -1, 0, 5},
      '{'h3D, 1020, 10, -1, 0, 4},
      '{'h1D,  250, 10, -1, 0, 6},
      '{'h1D,   10,  6, 13, 1, 3},
      '{'h22,    0,  4, -1, 1, 0},
      '{'h3D,    0,  0, -1, 0, 0},
      '{'h1D,  300,  2, -1, 0, 0},
      '{'h3D,  500,  3, -1, 0, 3}
   };

   int tx_n, rx_n, wr_n, ld_n, ld_seed, steps, gapc, carr_on, carr_off, charge_seen, off_seen;
   int tx_dat[64], tx_bts[64], tx_pln[64], tx_stp[64], tx_gap[64], rx_bts[64], wr_a[64], wr_d[64];
   int last_data, last_bits, card_type, bad_addr, cd;
   bit busy, is_rx;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_byte(input int a);
      return (a * 37 + 11) & 255;
   endfunction

   function automatic logic [3:0] ref_crc(input int addr, input int data, input int cw);
      logic [3:0] c;
      logic       fb;
      int         bits [20];
      int         n;
      c = 4'h5;
      n = 0;
      bits[n++] = 1;
      for (int b = cw - 2; b >= 0; b--) bits[n++] = (addr >> b) & 1;
      for (int b = 7; b >= 0; b--) bits[n++] = (data >> b) & 1;
      for (int i = 0; i < n; i++) begin
         fb = c[3] ^ bits[i][0];
         c  = {c[2:0], 1'b0};
         if (fb) c = c ^ 4'hC;
      end
      return c;
   endfunction

   // transmitter / receiver / keystream / buffer model, all at falling edges
   initial begin
      busy = 0; cd = 0; is_rx = 0; gapc = 0; carr_on = 0; carr_off = 0;
      forever begin
         @(negedge clk);
         tx_done_i = 1'b0;
         rx_done_i = 1'b0;
         gapc++;
         if (carrier_o) begin carr_on++; carr_off = 0; end
         else begin carr_off++; carr_on = 0; end
         if (ks_load_o) begin ld_n++; ld_seed = int'(ks_seed_o); end
         if (ks_step_o) steps++;
         if (wr_en_o && wr_n < 64) begin wr_a[wr_n] = int'(wr_addr_o); wr_d[wr_n] = int'(wr_data_o); wr_n++; end
         if ((done_o || err_o) && off_seen < 0) off_seen = carr_off;
         if (busy) begin
            cd--;
            if (cd == 0) begin
               if (is_rx) rx_done_i = 1'b1; else tx_done_i = 1'b1;
               busy = 0;
               gapc = 0;
            end
         end else if (tx_req_o) begin
            if (tx_n < 64) begin
               tx_dat[tx_n] = int'(tx_data_o); tx_bts[tx_n] = int'(tx_bits_o);
               tx_pln[tx_n] = int'(tx_plain_o); tx_stp[tx_n] = steps; tx_gap[tx_n] = gapc;
            end
            if (tx_n == 0) charge_seen = carr_on;
            tx_n++;
            steps = 0;
            last_data = int'(tx_data_o); last_bits = int'(tx_bits_o);
            busy = 1; cd = 3; is_rx = 0;
         end else if (rx_req_o) begin
            if (rx_n < 64) rx_bts[rx_n] = int'(rx_bits_o);
            rx_n++;
            if (rx_bits_o == 4'd6) rx_data_i = 12'(card_type);
            else begin
               int a, d;
               logic [3:0] c;
               a = last_data >> 1;
               d = exp_byte(a);
               c = ref_crc(a, d, last_bits);
               if (a == bad_addr) c = c ^ 4'h3;
               rx_data_i = {c, 8'(d)};
            end
            busy = 1; cd = 3; is_rx = 1;
         end
      end
   end

   task automatic run_session(input int ty, input int off, input int cnt, input int bad,
                              input int exp_err, input int exp_n);
      int k, cw, reads;
      card_type = ty; bad_addr = bad;
      tx_n = 0; rx_n = 0; wr_n = 0; ld_n = 0; ld_seed = -1; steps = 0;
      charge_seen = -1; off_seen = -1;
      @(negedge clk);
      start_i = 1'b1; offset_i = 10'(off); count_i = 11'(cnt);
      @(negedge clk);
      start_i = 1'b0;
      check(!done_o && !err_o, "R11", "flags cleared by start", int'({done_o, err_o}), 0);
      k = 0;
      while (!(done_o || err_o) && k < 40000) begin @(negedge clk); k++; end
      @(negedge clk);
      check(err_o == exp_err[0], "R11", "err flag", int'(err_o), exp_err);
      check(done_o == !exp_err[0], "R11", "done flag", int'(done_o), 1 - exp_err);
      check(off_seen >= OFFC, "R11", "carrier off time", off_seen, OFFC);
      check(charge_seen >= CH, "R1", "charge time", charge_seen, CH);
      check(tx_dat[0] == 'h55 && tx_bts[0] == 7 && tx_pln[0] == 1, "R2", "setup frame", tx_dat[0], 'h55);
      check(ld_n == 1 && ld_seed == 'h55, "R2", "seed load", ld_seed, 'h55);
      check(rx_bts[0] == 6, "R2", "type reply bits", rx_bts[0], 6);
      check(int'(type_o) == ty, "R3", "type output", int'(type_o), ty);
      if (ty == 'h1D || ty == 'h3D) begin
         cw = (ty == 'h3D) ? 11 : 9;
         reads = exp_n + exp_err;
         check(tx_dat[1] == 'h19 && tx_bts[1] == 6 && tx_pln[1] == 0, "R5", "ack frame", tx_dat[1], 'h19);
         check(tx_gap[1] >= GAP * DIV, "R5", "ack gap", tx_gap[1], GAP * DIV);
         check(tx_n == 2 + reads, "R9", "frame count", tx_n, 2 + reads);
         for (int i = 0; i < reads && i + 2 < 64; i++) begin
            check(tx_dat[i+2] == (((off + i) << 1) | 1), "R7", "read cmd value", tx_dat[i+2], ((off + i) << 1) | 1);
            check(tx_bts[i+2] == cw, "R3", "read cmd width", tx_bts[i+2], cw);
            check(tx_stp[i+2] == 4, "R6", "steps before read", tx_stp[i+2], 4);
            check(tx_gap[i+2] >= GAP * DIV, "R5", "read gap", tx_gap[i+2], GAP * DIV);
            check(rx_bts[i+1] == 12, "R7", "reply bits", rx_bts[i+1], 12);
         end
      end else begin
         check(tx_n == 1, "R4", "frames after bad type", tx_n, 1);
      end
      check(wr_n == exp_n, "R10", "bytes stored", wr_n, exp_n);
      for (int i = 0; i < wr_n && i < 64; i++) begin
         check(wr_a[i] == i, "R8", "store index", wr_a[i], i);
         check(wr_d[i] == exp_byte(off + i), "R8", "store data", wr_d[i], exp_byte(off + i));
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(!carrier_o && !done_o && !err_o && !tx_req_o && !rx_req_o && !wr_en_o,
            "R12", "state in reset", int'({carrier_o, done_o, err_o, tx_req_o, rx_req_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!carrier_o && !done_o && !err_o, "R12", "idle after reset", int'({carrier_o, done_o, err_o}), 0);

      for (int v = 0; v < 8; v++)
         run_session(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

      // reset in the middle of a session
      card_type = 'h3D; bad_addr = -1;
      @(negedge clk); start_i = 1'b1; offset_i = 10'd0; count_i = 11'd8;
      @(negedge clk); start_i = 1'b0;
      repeat (1200) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!carrier_o && !tx_req_o && !rx_req_o && !done_o && !err_o, "R12", "mid-session reset",
            int'({carrier_o, tx_req_o, rx_req_o, done_o, err_o}), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule